// File: doc/BRIEF.md
# Variable-Page-Size Translation Lookaside Buffer

This block is a fully associative address translation buffer. Each entry maps a pair of adjacent virtual pages, one even and one odd, onto two separate physical frames. Each entry also keeps its own page-size mask, so one buffer can hold 8 KB page pairs next to 32 MB page pairs. From that mask the block works out three things for each entry: how many tag bits take part in the compare, which address bit picks the even or odd half, and how many low address bits pass straight through as the page offset.

Software loads an entry through a clocked write port. The port takes four 32-bit register images: a tag word holding the VPN and ASID, a page-mask word, and one frame descriptor for each half. A combinational read port rebuilds the same four images from any entry. The lookup port is combinational. It takes a virtual address, the current 8-bit ASID and a write flag. It returns a 38-bit physical address, a status of exactly one of miss, invalid, modified or translated, and the read and write grants.

Top module: `vpt_tlb`

## Requirements
- R1: An entry's effective mask is its stored page mask ORed with 0x1FFF. The smallest page pair is therefore 8 KB, and address bits 12..0 never take part in the tag compare.
- R2: An entry matches when (vaddr AND NOT effective_mask) equals {VPN, 13'b0}, and either its global bit is 1 or its stored ASID equals the lookup ASID.
- R3: The half select is the address bit at the highest set bit of the effective mask. A 1 selects the odd half and a 0 selects the even half.
- R4: When a lookup is translated, paddr = {PFN, 12'b0} OR (vaddr AND (effective_mask >> 1)) for the selected half. In every other case paddr is 0.
- R5: A match whose selected half has its valid bit clear reports invalid, with no translation and no grants.
- R6: A read, or a write to a half whose dirty bit is 1, is translated. When translated, the read grant is 1 and the write grant equals the selected dirty bit. When not translated, both grants are 0.
- R7: A write that matches a valid half whose dirty bit is 0 reports modified, with no translation.
- R8: When no entry matches, miss is reported. Exactly one of miss, invalid, modified and translated (read grant) is 1 at any time.
- R9: When more than one entry matches, the entry with the lowest index decides the result.
- R10: A write stores VPN = tag word bits 31..13, ASID = tag word bits 7..0 and the whole page-mask word. The global bit is the AND of bit 0 of both frame descriptors. From each descriptor, valid comes from bit 1, dirty from bit 2, the cache attribute from bits 5..3 and the PFN from bits 31..6. The write takes effect on the next clock edge.
- R11: The read port returns the tag word as {VPN, 5'b0, ASID}, the stored page mask, and each descriptor as {PFN, attr, dirty, valid, global}.
- R12: A synchronous active-low reset clears every field of every entry to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Load entry wr_idx on the next edge |
| wr_idx | input | IDX_W | Entry index to load |
| wr_tag | input | 32 | Tag word: VPN in bits 31..13, ASID in bits 7..0 |
| wr_pmask | input | 32 | Page-mask word |
| wr_desc_even | input | 32 | Frame descriptor of the even half |
| wr_desc_odd | input | 32 | Frame descriptor of the odd half |
| rd_idx | input | IDX_W | Entry index to read back |
| rd_tag | output | 32 | Rebuilt tag word |
| rd_pmask | output | 32 | Stored page mask |
| rd_desc_even | output | 32 | Rebuilt even-half descriptor |
| rd_desc_odd | output | 32 | Rebuilt odd-half descriptor |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address-space identifier |
| lk_write | input | 1 | 1 for a store access |
| lk_paddr | output | 38 | Physical address, 0 unless translated |
| lk_miss | output | 1 | No entry matched |
| lk_invalid | output | 1 | Matched half not valid |
| lk_modified | output | 1 | Store to a clean half |
| lk_rd_ok | output | 1 | Translated; read granted |
| lk_wr_ok | output | 1 | Translated and writable |

## Verification
The lookup and read-back results are combinational and are due in the same cycle as their inputs. The bench drives them on a falling edge and samples one nanosecond later, well before the next rising edge. A load through the write port is due after exactly one rising edge, and so is a reset. The bench therefore samples the read port and the lookup on the falling edge after that rising edge, and never in the cycle in which the write is applied.

// File: rtl/vpt_tlb_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, entry layout and the conversions between the
// entry layout and the 32-bit register images. Assumes 32-bit virtual
// addresses and a 4 KB minimum single page (8 KB minimum page pair).
package vpt_tlb_pkg;
    localparam int VA_W       = 32;
    localparam int ASID_W     = 8;
    localparam int VPN_LSB    = 13;
    localparam int VPN_W      = VA_W - VPN_LSB;
    localparam int PAGE_SHIFT = 12;
    localparam int DESC_LSB   = 6;
    localparam int PFN_W      = VA_W - DESC_LSB;
    localparam int PA_W       = PFN_W + PAGE_SHIFT;
    localparam int ATTR_W     = 3;
    localparam logic [VA_W-1:0] FLOOR_MASK = 32'h0000_1FFF;

    // One half of a page pair.
    typedef struct packed {
        logic              valid;
        logic              dirty;
        logic [ATTR_W-1:0] attr;
        logic [PFN_W-1:0]  pfn;
    } tlb_half_t;

    // One complete entry.
    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [VA_W-1:0]   pmask;
        logic              glob;
        tlb_half_t         even;
        tlb_half_t         odd;
    } tlb_ent_t;

    // Extract one half from a frame descriptor image.
    function automatic tlb_half_t desc_to_half(input logic [31:0] d);
        tlb_half_t h;
        h.valid = d[1];
        h.dirty = d[2];
        h.attr  = d[5:3];
        h.pfn   = d[31:DESC_LSB];
        return h;
    endfunction

    // Rebuild a frame descriptor image from one half and the global bit.
    function automatic logic [31:0] half_to_desc(input tlb_half_t h, input logic g);
        return {h.pfn, h.attr, h.dirty, h.valid, g};
    endfunction
endpackage

// File: rtl/vpt_tlb_store.sv
`timescale 1ns/1ps
// Entry storage: holds NUM_ENTRIES entries, loads one per clock from the
// register images and rebuilds the images for any entry combinationally.
// Assumes indexes at or above NUM_ENTRIES are ignored on write and read 0.
module vpt_tlb_store
    import vpt_tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_tag,
    input  logic [31:0]      wr_pmask,
    input  logic [31:0]      wr_desc_even,
    input  logic [31:0]      wr_desc_odd,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_tag,
    output logic [31:0]      rd_pmask,
    output logic [31:0]      rd_desc_even,
    output logic [31:0]      rd_desc_odd,
    output tlb_ent_t         ent_q [NUM_ENTRIES]
);
    tlb_ent_t new_ent;
    tlb_ent_t rd_ent;

    // Assemble the entry image that a write would store.
    always_comb begin
        new_ent       = '0;
        new_ent.vpn   = wr_tag[VA_W-1:VPN_LSB];
        new_ent.asid  = wr_tag[ASID_W-1:0];
        new_ent.pmask = wr_pmask;
        new_ent.glob  = wr_desc_even[0] & wr_desc_odd[0];
        new_ent.even  = desc_to_half(wr_desc_even);
        new_ent.odd   = desc_to_half(wr_desc_odd);
    end

    // Store one entry per clock; reset clears the whole array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENTRIES; i++) ent_q[i] <= '0;
        end else if (wr_en && (int'(wr_idx) < NUM_ENTRIES)) begin
            ent_q[wr_idx] <= new_ent;
        end
    end

    // Select the entry named by the read index.
    always_comb begin
        rd_ent = '0;
        if (int'(rd_idx) < NUM_ENTRIES) rd_ent = ent_q[rd_idx];
    end

    // Rebuild the register images of the selected entry.
    always_comb begin
        rd_tag       = {rd_ent.vpn, {(VPN_LSB-ASID_W){1'b0}}, rd_ent.asid};
        rd_pmask     = rd_ent.pmask;
        rd_desc_even = half_to_desc(rd_ent.even, rd_ent.glob);
        rd_desc_odd  = half_to_desc(rd_ent.odd,  rd_ent.glob);
    end

    // R10
    wr_vpn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_idx) < NUM_ENTRIES))
        |=> (ent_q[$past(wr_idx)].vpn == $past(wr_tag[VA_W-1:VPN_LSB])));

    // R10
    wr_glob_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_idx) < NUM_ENTRIES))
        |=> (ent_q[$past(wr_idx)].glob == ($past(wr_desc_even[0]) && $past(wr_desc_odd[0]))));
endmodule

// File: rtl/vpt_tlb_match.sv
`timescale 1ns/1ps
// Per-entry comparator: works out the effective mask of one entry and from
// it the tag compare, the half select and the offset mask for one address.
// Assumes the stored page mask is a contiguous run of ones above bit 12.
module vpt_tlb_match
    import vpt_tlb_pkg::*;
(
    input  tlb_ent_t          ent,
    input  logic [VA_W-1:0]   vaddr,
    input  logic [ASID_W-1:0] asid,
    output logic              hit,
    output logic              odd_sel,
    output logic [VA_W-1:0]   off_mask
);
    logic [VA_W-1:0] eff_mask;
    logic [VA_W-1:0] top_bit;
    logic            tag_eq;
    logic            asid_ok;

    // Derive the effective mask, its top bit and the offset mask.
    always_comb begin
        eff_mask = ent.pmask | FLOOR_MASK;
        top_bit  = eff_mask & ~(eff_mask >> 1);
        off_mask = eff_mask >> 1;
    end

    // Compare the tag and the address space.
    always_comb begin
        tag_eq  = ((vaddr & ~eff_mask) == {ent.vpn, {VPN_LSB{1'b0}}});
        asid_ok = ent.glob || (ent.asid == asid);
        hit     = tag_eq && asid_ok;
        odd_sel = |(vaddr & top_bit);
    end
endmodule

// File: rtl/vpt_tlb_pick.sv
`timescale 1ns/1ps
// Priority picker: reports whether any entry matched and returns the index
// of the lowest-numbered match. Assumes the match vector is settled.
module vpt_tlb_pick #(
    parameter int NUM_ENTRIES = 16,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_ENTRIES-1:0] match_vec,
    output logic                   found,
    output logic [IDX_W-1:0]       sel_idx
);
    // Scan from the top so the lowest index is written last and wins.
    always_comb begin
        found   = 1'b0;
        sel_idx = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                found   = 1'b1;
                sel_idx = IDX_W'(i);
            end
        end
    end

    // R9
    pick_is_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> match_vec[sel_idx]);

    // R9
    pick_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> ((match_vec & ((NUM_ENTRIES'(1) << sel_idx) - NUM_ENTRIES'(1))) == '0));

    // R8
    pick_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match_vec == '0) |-> !found);
endmodule

// File: rtl/vpt_tlb_resolve.sv
`timescale 1ns/1ps
// Result stage: from the chosen entry and half, forms the status, the grants
// and the physical address. Assumes sel is only meaningful when found is 1.
module vpt_tlb_resolve
    import vpt_tlb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            found,
    input  tlb_ent_t        sel,
    input  logic            odd_sel,
    input  logic [VA_W-1:0] off_mask,
    input  logic [VA_W-1:0] vaddr,
    input  logic            is_write,
    output logic [PA_W-1:0] paddr,
    output logic            miss,
    output logic            invalid,
    output logic            modified,
    output logic            rd_ok,
    output logic            wr_ok
);
    tlb_half_t half;
    logic      done;

    // Choose the half of the pair named by the select bit.
    always_comb begin
        half = odd_sel ? sel.odd : sel.even;
    end

    // Classify the access into exactly one status.
    always_comb begin
        miss     = !found;
        invalid  = found && !half.valid;
        modified = found && half.valid && is_write && !half.dirty;
        done     = found && half.valid && (!is_write || half.dirty);
        rd_ok    = done;
        wr_ok    = done && half.dirty;
    end

    // Merge the frame number with the pass-through offset.
    always_comb begin
        paddr = '0;
        if (done) paddr = {half.pfn, {PAGE_SHIFT{1'b0}}} | PA_W'(vaddr & off_mask);
    end

    // R7
    mod_needs_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        modified |-> is_write);

    // R6
    wgrant_implies_rgrant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |-> rd_ok);

    // R4
    low_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ok |-> (paddr[PAGE_SHIFT-1:0] == vaddr[PAGE_SHIFT-1:0]));

    // R4
    no_xlate_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ok |-> (paddr == '0));
endmodule

// File: rtl/vpt_tlb.sv
`timescale 1ns/1ps
// Top level: a fully associative buffer of page-pair entries, each with its
// own page-size mask. It has a clocked load port, a combinational read-back
// port and a combinational lookup port. Assumes software keeps page masks
// contiguous; when entries overlap, the lowest index decides.
module vpt_tlb
    import vpt_tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_tag,
    input  logic [31:0]      wr_pmask,
    input  logic [31:0]      wr_desc_even,
    input  logic [31:0]      wr_desc_odd,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_tag,
    output logic [31:0]      rd_pmask,
    output logic [31:0]      rd_desc_even,
    output logic [31:0]      rd_desc_odd,
    input  logic [31:0]      lk_vaddr,
    input  logic [7:0]       lk_asid,
    input  logic             lk_write,
    output logic [37:0]      lk_paddr,
    output logic             lk_miss,
    output logic             lk_invalid,
    output logic             lk_modified,
    output logic             lk_rd_ok,
    output logic             lk_wr_ok
);
    tlb_ent_t               ent_q [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] match_vec;
    logic [NUM_ENTRIES-1:0] odd_vec;
    logic [VA_W-1:0]        off_vec [NUM_ENTRIES];
    logic                   found;
    logic [IDX_W-1:0]       sel_idx;
    tlb_ent_t               sel_ent;
    logic                   sel_odd;
    logic [VA_W-1:0]        sel_off;

    vpt_tlb_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_idx       (wr_idx),
        .wr_tag       (wr_tag),
        .wr_pmask     (wr_pmask),
        .wr_desc_even (wr_desc_even),
        .wr_desc_odd  (wr_desc_odd),
        .rd_idx       (rd_idx),
        .rd_tag       (rd_tag),
        .rd_pmask     (rd_pmask),
        .rd_desc_even (rd_desc_even),
        .rd_desc_odd  (rd_desc_odd),
        .ent_q        (ent_q)
    );

    // One comparator per entry.
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
        vpt_tlb_match u_match (
            .ent      (ent_q[g]),
            .vaddr    (lk_vaddr),
            .asid     (lk_asid),
            .hit      (match_vec[g]),
            .odd_sel  (odd_vec[g]),
            .off_mask (off_vec[g])
        );
    end

    vpt_tlb_pick #(.NUM_ENTRIES(NUM_ENTRIES)) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .match_vec (match_vec),
        .found     (found),
        .sel_idx   (sel_idx)
    );

    // Route the winning entry and its compare results to the result stage.
    always_comb begin
        sel_ent = ent_q[sel_idx];
        sel_odd = odd_vec[sel_idx];
        sel_off = off_vec[sel_idx];
    end

    vpt_tlb_resolve u_resolve (
        .clk      (clk),
        .rst_n    (rst_n),
        .found    (found),
        .sel      (sel_ent),
        .odd_sel  (sel_odd),
        .off_mask (sel_off),
        .vaddr    (lk_vaddr),
        .is_write (lk_write),
        .paddr    (lk_paddr),
        .miss     (lk_miss),
        .invalid  (lk_invalid),
        .modified (lk_modified),
        .rd_ok    (lk_rd_ok),
        .wr_ok    (lk_wr_ok)
    );

    // R8
    one_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({lk_miss, lk_invalid, lk_modified, lk_rd_ok}));

    // R5
    invalid_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_invalid |-> (!lk_rd_ok && !lk_wr_ok));
endmodule

// File: tb/vpt_tlb_bench.sv
`timescale 1ns/1ps
// Bench: loads entries with 8 KB, 32 KB and 32 MB page pairs, walks a table
// of lookups, then runs directed read-back, priority and reset tests.
module vpt_tlb_bench;
    localparam int N     = 16;
    localparam int IDX_W = $clog2(N);
    localparam logic [2:0] ST_MISS = 3'd0, ST_INV = 3'd1, ST_MOD = 3'd2, ST_OK = 3'd3;

    typedef struct packed {
        logic [31:0] va;
        logic [7:0]  asid;
        logic        wr;
        logic [2:0]  st;
        logic [37:0] pa;
        logic        pw;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{32'h0040_2ABC, 8'h05, 1'b0, ST_OK,   38'h0_0010_0ABC, 1'b1, 8'd3},  // R3 even half, 8 KB
        '{32'h0040_3123, 8'h05, 1'b1, ST_MOD,  38'h0,            1'b0, 8'd7},  // R7 store to clean odd
        '{32'h0040_3123, 8'h05, 1'b0, ST_OK,   38'h0_0020_0123, 1'b0, 8'd6},  // R6 read of clean half
        '{32'h0040_2ABC, 8'h06, 1'b0, ST_MISS, 38'h0,            1'b0, 8'd2},  // R2 ASID differs
        '{32'h0040_2ABC, 8'h05, 1'b1, ST_OK,   38'h0_0010_0ABC, 1'b1, 8'd6},  // R6 store to dirty half
        '{32'h1000_3456, 8'h99, 1'b1, ST_OK,   38'h0_0040_3456, 1'b1, 8'd2},  // R2 global entry
        '{32'h1000_5000, 8'h22, 1'b0, ST_INV,  38'h0,            1'b0, 8'd5},  // R5 odd half not valid
        '{32'h1000_8000, 8'h22, 1'b0, ST_MISS, 38'h0,            1'b0, 8'd8},  // R8 past 32 KB pair
        '{32'h82AB_CDEF, 8'h07, 1'b0, ST_OK,   38'h0_10AB_CDEF, 1'b0, 8'd4},  // R4 24-bit offset
        '{32'h8312_3456, 8'h07, 1'b1, ST_OK,   38'h0_1112_3456, 1'b1, 8'd3},  // R3 select bit 24
        '{32'h82AB_CDEF, 8'h07, 1'b1, ST_MOD,  38'h0,            1'b0, 8'd7},  // R7 clean even, 32 MB
        '{32'h8400_0000, 8'h07, 1'b0, ST_MISS, 38'h0,            1'b0, 8'd8},  // R8 beyond 32 MB pair
        '{32'h0040_1FFF, 8'h05, 1'b0, ST_MISS, 38'h0,            1'b0, 8'd1},  // R1 8 KB floor
        '{32'h83FF_FFFF, 8'h03, 1'b0, ST_MISS, 38'h0,            1'b0, 8'd2}   // R2 ASID, not global
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [IDX_W-1:0] wr_idx = '0;
    logic [31:0]      wr_tag = '0, wr_pmask = '0, wr_desc_even = '0, wr_desc_odd = '0;
    logic [IDX_W-1:0] rd_idx = '0;
    logic [31:0]      rd_tag, rd_pmask, rd_desc_even, rd_desc_odd;
    logic [31:0]      lk_vaddr = '0;
    logic [7:0]       lk_asid = '0;
    logic             lk_write = 1'b0;
    logic [37:0]      lk_paddr;
    logic             lk_miss, lk_invalid, lk_modified, lk_rd_ok, lk_wr_ok;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    vpt_tlb #(.NUM_ENTRIES(N)) u_vpt_tlb (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_pmask(wr_pmask),
        .wr_desc_even(wr_desc_even), .wr_desc_odd(wr_desc_odd),
        .rd_idx(rd_idx), .rd_tag(rd_tag), .rd_pmask(rd_pmask),
        .rd_desc_even(rd_desc_even), .rd_desc_odd(rd_desc_odd),
        .lk_vaddr(lk_vaddr), .lk_asid(lk_asid), .lk_write(lk_write),
        .lk_paddr(lk_paddr), .lk_miss(lk_miss), .lk_invalid(lk_invalid),
        .lk_modified(lk_modified), .lk_rd_ok(lk_rd_ok), .lk_wr_ok(lk_wr_ok)
    );

    // Load one entry: applied on a falling edge, stored at the next rising edge.
    task automatic load(input int idx, input logic [31:0] t, input logic [31:0] m,
                        input logic [31:0] e, input logic [31:0] o);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IDX_W'(idx);
        wr_tag = t; wr_pmask = m; wr_desc_even = e; wr_desc_odd = o;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Turn the status outputs into one code; 7 flags a broken one-hot.
    function automatic logic [2:0] status_code();
        if ($countones({lk_miss, lk_invalid, lk_modified, lk_rd_ok}) != 1) return 3'd7;
        if (lk_miss)     return ST_MISS;
        if (lk_invalid)  return ST_INV;
        if (lk_modified) return ST_MOD;
        return ST_OK;
    endfunction

    // Apply one lookup and compare status, address and grants.
    task automatic lookup(input logic [31:0] va, input logic [7:0] as, input logic w,
                          input logic [2:0] st, input logic [37:0] pa, input logic pw,
                          input int req);
        logic [2:0] got;
        @(negedge clk);
        lk_vaddr = va; lk_asid = as; lk_write = w;
        #1;
        got = status_code();
        checks++;
        if (got !== st || lk_paddr !== pa || lk_wr_ok !== pw ||
            lk_rd_ok !== (st == ST_OK)) begin
            fails++;
            $display("FAIL R%0d lookup va=%h: status=%0d paddr=%h wok=%b rok=%b expected status=%0d paddr=%h wok=%b",
                     req, va, got, lk_paddr, lk_wr_ok, lk_rd_ok, st, pa, pw);
        end
    endtask

    // Read one entry back and compare all four images.
    task automatic readback(input int idx, input logic [31:0] t, input logic [31:0] m,
                            input logic [31:0] e, input logic [31:0] o, input int req);
        @(negedge clk);
        rd_idx = IDX_W'(idx);
        #1;
        checks++;
        if (rd_tag !== t || rd_pmask !== m || rd_desc_even !== e || rd_desc_odd !== o) begin
            fails++;
            $display("FAIL R%0d read idx %0d: %h %h %h %h expected %h %h %h %h",
                     req, idx, rd_tag, rd_pmask, rd_desc_even, rd_desc_odd, t, m, e, o);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12 reset state: entry zeroed, unrelated address misses
        readback(0, 32'h0, 32'h0, 32'h0, 32'h0, 12);
        lookup(32'h4000_0000, 8'h00, 1'b0, ST_MISS, 38'h0, 1'b0, 12);

        // 8 KB pair: even pfn 0x100 V D, odd pfn 0x200 V
        load(0, 32'h0040_2005, 32'h0000_0000, 32'h0000_4006, 32'h0000_8002);
        // 32 KB pair, global: even pfn 0x400 V D, odd pfn 0x800 not valid
        load(1, 32'h1000_0022, 32'h0000_6000, 32'h0001_0007, 32'h0002_0001);
        // 32 MB pair: even pfn 0x10000 V, odd pfn 0x11000 V D
        load(2, 32'h8200_0007, 32'h01FF_E000, 32'h0040_0002, 32'h0044_0006);

        for (int i = 0; i < NV; i++)
            lookup(TBL[i].va, TBL[i].asid, TBL[i].wr, TBL[i].st, TBL[i].pa, TBL[i].pw, int'(TBL[i].req));

        // R11 read-back of loaded entries
        readback(1, 32'h1000_0022, 32'h0000_6000, 32'h0001_0007, 32'h0002_0001, 11);
        readback(2, 32'h8200_0007, 32'h01FF_E000, 32'h0040_0002, 32'h0044_0006, 11);

        // R10 field extraction: tag bits 12..8 dropped, global needs both bit 0s
        load(4, 32'h00A0_1FFF, 32'h0000_6000, 32'h0000_1569, 32'h0000_1992);
        readback(4, 32'h00A0_00FF, 32'h0000_6000, 32'h0000_1568, 32'h0000_1992, 10);

        // R9 duplicate of entry 0 at index 3 with other frames: entry 0 wins
        load(3, 32'h0040_2005, 32'h0000_0000, 32'h0000_CCC6, 32'h0001_1106);
        lookup(32'h0040_2ABC, 8'h05, 1'b0, ST_OK, 38'h0_0010_0ABC, 1'b1, 9);
        // R9 move entry 0 away: the index-3 duplicate now decides
        load(0, 32'h0080_0005, 32'h0000_0000, 32'h0000_4006, 32'h0000_8002);
        lookup(32'h0040_2ABC, 8'h05, 1'b0, ST_OK, 38'h0_0033_3ABC, 1'b1, 9);
        lookup(32'h0040_3010, 8'h05, 1'b1, ST_OK, 38'h0_0044_4010, 1'b1, 3);

        // R12 reset mid-run clears loaded entries
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        readback(2, 32'h0, 32'h0, 32'h0, 32'h0, 12);
        lookup(32'h82AB_CDEF, 8'h07, 1'b0, ST_MISS, 38'h0, 1'b0, 12);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule